// File: doc/BRIEF.md
# Transparent Translation Window Matcher

This block decides whether a memory access falls inside one of a small set of transparent translation windows. A window is a programmed 32-bit register that names an upper-address-byte base, a per-bit don't-care mask, an access-mode qualifier and a write-protect flag. An access that lands in a window bypasses the page tables. Its physical address equals its logical address, and the window alone sets its permissions. Instruction fetches are checked against one bank of window registers and data accesses against a second bank. Inside a bank, the lowest-numbered matching register decides the result.

Requests enter through a valid/ready handshake carrying the address and the access attributes: supervisor, code/data, store and probe. Each accepted request yields exactly one response one cycle later on a valid/ready output. A stalled response is held unchanged. A new request is accepted only when the output register is empty or is being drained in the same cycle, so `req_ready` is high exactly when `rsp_valid` is low or `rsp_ready` is high. The window registers are plain static inputs and are sampled in the cycle the request is accepted.

Each window register uses this layout:
- Bits 31:24 hold the base.
- Bits 23:16 hold the mask.
- Bit 15 is the enable.
- Bits 14:13 hold the mode field.
- Bit 2 is write-protect.

All other bits, including a cache-mode field at bits 6:5, do not affect matching.

Top module: `ttm_matcher`

## Requirements
- R1: A window register whose enable bit (bit 15) is 0 never matches, whatever its other fields hold.
- R2: Mode field bits 14:13 value 2'b00 matches only user accesses (req_super=0), value 2'b01 matches only supervisor accesses, and values 2'b10 and 2'b11 match either mode.
- R3: Address bit 24+i is compared with base bit 24+i only when mask bit 16+i is 0; a mask bit of 1 makes that address bit don't-care, and address bits 23:0 never take part.
- R4: An access with req_code=1 is checked only against the instruction bank (ttr_code) and one with req_code=0 only against the data bank (ttr_data).
- R5: When several registers of the selected bank match, the lowest-indexed one (register k occupies bits 32k+31:32k of the bank port) supplies the write-protect bit.
- R6: On a match, rsp_hit, rsp_rd and rsp_ex are 1 and rsp_wr is the inverse of the winning register's write-protect bit (bit 2); on a miss, all of rsp_hit, rsp_rd, rsp_wr, rsp_ex, rsp_wp_fault and rsp_probe_stat are 0.
- R7: A store that matches a write-protected window gives rsp_wp_fault=1 and rsp_wr=0; loads, misses and stores to unprotected windows give rsp_wp_fault=0.
- R8: A probe access that matches reports rsp_probe_stat=8'h03 (bit 0 resident, bit 1 transparent, all other bits 0); a non-probe access or a miss reports 8'h00.
- R9: A request accepted on a clock edge yields rsp_valid at the next edge. rsp_addr equals the request address. While rsp_valid=1 and rsp_ready=0, all response outputs hold their values. req_ready = !rsp_valid || rsp_ready.
- R10: During and directly after reset, rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W (32) | Logical address |
| req_super | input | 1 | 1 = supervisor access, 0 = user |
| req_code | input | 1 | 1 = instruction fetch, 0 = data access |
| req_store | input | 1 | 1 = write access |
| req_probe | input | 1 | 1 = probe (status-reporting) access |
| ttr_code | input | REGS_PER_SET*32 (64) | Instruction-bank window registers, register k in bits 32k+31:32k |
| ttr_data | input | REGS_PER_SET*32 (64) | Data-bank window registers, same packing |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | A window matched |
| rsp_rd | output | 1 | Read granted |
| rsp_wr | output | 1 | Write granted |
| rsp_ex | output | 1 | Execute granted |
| rsp_wp_fault | output | 1 | Store hit a write-protected window |
| rsp_probe_stat | output | 8 | Probe status, bit 1 transparent, bit 0 resident |
| rsp_addr | output | ADDR_W (32) | Physical address, equal to the logical address |

## Verification
All the matching logic is combinational in front of a single output register. A fault in the base/mask compare, the mode decode, the bank select or the priority chain therefore shows up on the permission, fault or probe outputs of the very next response. The bench's reference model reports that response as a mismatch at once. A fault in the output register's valid or hold behaviour shows up in one of three ways: a response is lost or duplicated, the output changes during a stall, or rsp_valid is missing one cycle after acceptance. The bench varies back-pressure so that each of these is seen within a cycle or two.

// File: rtl/ttm_pkg.sv
package ttm_pkg;
  localparam int TTR_W    = 32;
  localparam int FIELD_W  = 8;
  localparam int MODE_W   = 2;
  localparam int BASE_LSB = 24;
  localparam int MASK_LSB = 16;
  localparam int EN_BIT   = 15;
  localparam int MODE_LSB = 13;
  localparam int WP_BIT   = 2;

  localparam logic [MODE_W-1:0] MODE_USER_ONLY  = 2'b00;
  localparam logic [MODE_W-1:0] MODE_SUPER_ONLY = 2'b01;

  // bits that take part in matching; everything else is ignored
  localparam logic [TTR_W-1:0] USED_MASK = 32'hFFFF_E004;

  localparam int STAT_W        = 8;
  localparam int STAT_RESIDENT = 0;
  localparam int STAT_TRANSP   = 1;

  typedef struct packed {
    logic              hit;
    logic              rd;
    logic              wr;
    logic              ex;
    logic              wp_fault;
    logic [STAT_W-1:0] stat;
  } ttm_result_t;
endpackage

// File: rtl/ttm_entry_match.sv
module ttm_entry_match
  import ttm_pkg::*;
(
  input  logic [TTR_W-1:0]   ttr,
  input  logic [FIELD_W-1:0] addr_hi,
  input  logic               is_super,
  output logic               hit,
  output logic               wp
);
  logic [FIELD_W-1:0] base_f;
  logic [FIELD_W-1:0] care_f;
  logic [MODE_W-1:0]  mode_f;
  logic               mode_ok;
  logic               addr_ok;
  logic               unused_bits;

  assign base_f = ttr[BASE_LSB +: FIELD_W];
  assign care_f = ~ttr[MASK_LSB +: FIELD_W];
  assign mode_f = ttr[MODE_LSB +: MODE_W];

  always_comb begin
    case (mode_f)
      MODE_USER_ONLY:  mode_ok = !is_super;
      MODE_SUPER_ONLY: mode_ok = is_super;
      default:         mode_ok = 1'b1;
    endcase
  end

  assign addr_ok = ((addr_hi ^ base_f) & care_f) == '0;
  assign hit     = ttr[EN_BIT] & mode_ok & addr_ok;
  assign wp      = ttr[WP_BIT];

  assign unused_bits = ^(ttr & ~USED_MASK);
endmodule

// File: rtl/ttm_prio_select.sv
module ttm_prio_select #(
  parameter int N = 2
) (
  input  logic [N-1:0] hit_vec,
  input  logic [N-1:0] wp_vec,
  output logic         any_hit,
  output logic         sel_wp
);
  always_comb begin
    sel_wp = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel_wp = wp_vec[i];
    end
  end
  assign any_hit = |hit_vec;
endmodule

// File: rtl/ttm_set_eval.sv
module ttm_set_eval
  import ttm_pkg::*;
#(
  parameter int N = 2
) (
  input  logic [N*TTR_W-1:0] regs,
  input  logic [FIELD_W-1:0] addr_hi,
  input  logic               is_super,
  output logic               any_hit,
  output logic               sel_wp
);
  logic [N-1:0] hit_vec;
  logic [N-1:0] wp_vec;

  for (genvar g = 0; g < N; g++) begin : g_entry
    ttm_entry_match entry_i (
      .ttr      (regs[g*TTR_W +: TTR_W]),
      .addr_hi  (addr_hi),
      .is_super (is_super),
      .hit      (hit_vec[g]),
      .wp       (wp_vec[g])
    );
  end

  ttm_prio_select #(.N(N)) prio_i (
    .hit_vec (hit_vec),
    .wp_vec  (wp_vec),
    .any_hit (any_hit),
    .sel_wp  (sel_wp)
  );
endmodule

// File: rtl/ttm_out_stage.sv
module ttm_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/ttm_matcher.sv
module ttm_matcher
  import ttm_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int REGS_PER_SET = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic                          req_super,
  input  logic                          req_code,
  input  logic                          req_store,
  input  logic                          req_probe,
  input  logic [REGS_PER_SET*TTR_W-1:0] ttr_code,
  input  logic [REGS_PER_SET*TTR_W-1:0] ttr_data,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic                          rsp_hit,
  output logic                          rsp_rd,
  output logic                          rsp_wr,
  output logic                          rsp_ex,
  output logic                          rsp_wp_fault,
  output logic [STAT_W-1:0]             rsp_probe_stat,
  output logic [ADDR_W-1:0]             rsp_addr
);
  localparam int RES_W = $bits(ttm_result_t);
  localparam int PIPE_W = RES_W + ADDR_W;

  logic [FIELD_W-1:0] addr_hi;
  logic               code_hit, code_wp;
  logic               data_hit, data_wp;
  logic               sel_hit, sel_wp;
  ttm_result_t        res_d, res_q;
  logic [PIPE_W-1:0]  pipe_q;

  assign addr_hi = req_addr[ADDR_W-1 -: FIELD_W];

  ttm_set_eval #(.N(REGS_PER_SET)) code_set_i (
    .regs     (ttr_code),
    .addr_hi  (addr_hi),
    .is_super (req_super),
    .any_hit  (code_hit),
    .sel_wp   (code_wp)
  );

  ttm_set_eval #(.N(REGS_PER_SET)) data_set_i (
    .regs     (ttr_data),
    .addr_hi  (addr_hi),
    .is_super (req_super),
    .any_hit  (data_hit),
    .sel_wp   (data_wp)
  );

  assign sel_hit = req_code ? code_hit : data_hit;
  assign sel_wp  = req_code ? code_wp  : data_wp;

  always_comb begin
    res_d          = '0;
    res_d.hit      = sel_hit;
    res_d.rd       = sel_hit;
    res_d.ex       = sel_hit;
    res_d.wr       = sel_hit & ~sel_wp;
    res_d.wp_fault = sel_hit & sel_wp & req_store;
    if (sel_hit && req_probe) begin
      res_d.stat[STAT_RESIDENT] = 1'b1;
      res_d.stat[STAT_TRANSP]   = 1'b1;
    end
  end

  ttm_out_stage #(.W(PIPE_W)) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   ({res_d, req_addr}),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (pipe_q)
  );

  assign res_q          = pipe_q[PIPE_W-1 -: RES_W];
  assign rsp_addr       = pipe_q[ADDR_W-1:0];
  assign rsp_hit        = res_q.hit;
  assign rsp_rd         = res_q.rd;
  assign rsp_wr         = res_q.wr;
  assign rsp_ex         = res_q.ex;
  assign rsp_wp_fault   = res_q.wp_fault;
  assign rsp_probe_stat = res_q.stat;
endmodule

// File: rtl/ttm_matcher_chk.sv
module ttm_matcher_chk
  import ttm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic              rsp_rd,
  input logic              rsp_wr,
  input logic              rsp_ex,
  input logic              rsp_wp_fault,
  input logic [STAT_W-1:0] rsp_probe_stat,
  input logic [ADDR_W-1:0] rsp_addr
);
  localparam logic [STAT_W-1:0] STAT_HIT = STAT_W'(3);

  // R6
  grant_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_wr |-> rsp_hit && rsp_rd && rsp_ex);

  // R6
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> !rsp_rd && !rsp_wr && !rsp_ex && !rsp_wp_fault && rsp_probe_stat == '0);

  // R7
  fault_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_wp_fault |-> rsp_hit && !rsp_wr);

  // R8
  probe_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_probe_stat != '0 |-> rsp_hit && rsp_probe_stat == STAT_HIT);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid &&
      $stable({rsp_hit, rsp_rd, rsp_wr, rsp_ex, rsp_wp_fault, rsp_probe_stat, rsp_addr}));

  // R9
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);
endmodule

bind ttm_matcher ttm_matcher_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_hit        (rsp_hit),
  .rsp_rd         (rsp_rd),
  .rsp_wr         (rsp_wr),
  .rsp_ex         (rsp_ex),
  .rsp_wp_fault   (rsp_wp_fault),
  .rsp_probe_stat (rsp_probe_stat),
  .rsp_addr       (rsp_addr)
);

// File: tb/ttm_matcher_tb_top.sv
`timescale 1ns/1ps
module ttm_matcher_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_super = 1'b0, req_code = 1'b0, req_store = 1'b0, req_probe = 1'b0;
  logic [63:0] ttr_code = '0, ttr_data = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic        rsp_hit, rsp_rd, rsp_wr, rsp_ex, rsp_wp_fault;
  logic [7:0]  rsp_probe_stat;
  logic [31:0] rsp_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit stall_en = 0;

  typedef struct {
    logic [44:0] v;   // {hit, rd, wr, ex, fault, stat[7:0], addr[31:0]}
    string       tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  ttm_matcher dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_super(req_super), .req_code(req_code),
    .req_store(req_store), .req_probe(req_probe), .ttr_code(ttr_code),
    .ttr_data(ttr_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex),
    .rsp_wp_fault(rsp_wp_fault), .rsp_probe_stat(rsp_probe_stat), .rsp_addr(rsp_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] base, input logic [7:0] mask,
                                     input bit en, input logic [1:0] mode, input bit wp);
    logic [31:0] r;
    r = {base, mask, en, mode, 13'h0};
    r[2] = wp;
    return r;
  endfunction

  function automatic bit win_hit(input logic [31:0] r, input logic [31:0] a, input bit s);
    if (!r[15]) return 0;
    if (r[14:13] == 2'b00 && s) return 0;
    if (r[14:13] == 2'b01 && !s) return 0;
    for (int b = 0; b < 8; b++)
      if (!r[16+b] && (a[24+b] != r[24+b])) return 0;
    return 1;
  endfunction

  function automatic logic [44:0] model(input logic [31:0] a, input bit s, input bit st,
                                        input bit pr, input logic [31:0] r0, input logic [31:0] r1);
    bit found = 0;
    bit wpv = 0;
    logic [7:0] stat;
    if (win_hit(r0, a, s)) begin found = 1; wpv = r0[2]; end
    else if (win_hit(r1, a, s)) begin found = 1; wpv = r1[2]; end
    stat = (found && pr) ? 8'h03 : 8'h00;
    if (!found) return {5'b0, 8'h00, a};
    return {1'b1, 1'b1, !wpv, 1'b1, wpv && st, stat, a};
  endfunction

  // driver: called at a falling edge
  task automatic send(input logic [31:0] a, input bit s, input bit c, input bit st, input bit pr,
                      input logic [31:0] c0, input logic [31:0] c1,
                      input logic [31:0] d0, input logic [31:0] d1, input string tag);
    exp_t e;
    req_addr = a; req_super = s; req_code = c; req_store = st; req_probe = pr;
    ttr_code = {c1, c0}; ttr_data = {d1, d0};
    req_valid = 1'b1;
    e.v = c ? model(a, s, st, pr, c0, c1) : model(a, s, st, pr, d0, d1);
    e.tag = tag;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R9 latency", {63'b0, rsp_valid}, 64'd1);
  endtask

  // back-pressure
  initial begin
    forever begin
      @(negedge clk);
      rsp_ready = stall_en ? ($urandom % 4 != 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    logic [44:0] snap;
    bit held = 0;
    exp_t e;
    forever begin
      @(negedge clk); #2;
      if (rst_n) begin
        if (held)
          chk(rsp_valid && {rsp_hit, rsp_rd, rsp_wr, rsp_ex, rsp_wp_fault, rsp_probe_stat, rsp_addr} == snap,
              "R9 stall hold", {19'b0, rsp_hit, rsp_rd, rsp_wr, rsp_ex, rsp_wp_fault, rsp_probe_stat, rsp_addr},
              {19'b0, snap});
        held = rsp_valid && !rsp_ready;
        snap = {rsp_hit, rsp_rd, rsp_wr, rsp_ex, rsp_wp_fault, rsp_probe_stat, rsp_addr};
        if (rsp_valid && rsp_ready) begin
          if (q.size() == 0) begin
            chk(0, "R9 unexpected response", {19'b0, snap}, 64'd0);
          end else begin
            e = q.pop_front();
            chk(snap == e.v, e.tag, {19'b0, snap}, {19'b0, e.v});
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "watchdog", 64'd0, 64'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w0, w1, ra, rb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R10 reset valid", {63'b0, rsp_valid}, 64'd0);
    chk(req_ready === 1'b1, "R10 reset ready", {63'b0, req_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R10 after reset", {63'b0, rsp_valid}, 64'd0);

    // R1 enable
    send(32'h4000_1234, 0, 1, 0, 0, mk(8'h40, 8'h00, 0, 2'b10, 0), 0, 0, 0, "R1 disabled");
    send(32'h4000_1234, 0, 1, 0, 0, mk(8'h40, 8'h00, 1, 2'b10, 0), 0, 0, 0, "R1 enabled");
    // R2 mode field
    send(32'h4000_0000, 1, 0, 0, 0, 0, 0, mk(8'h40, 0, 1, 2'b00, 0), 0, "R2 user-only super");
    send(32'h4000_0000, 0, 0, 0, 0, 0, 0, mk(8'h40, 0, 1, 2'b00, 0), 0, "R2 user-only user");
    send(32'h4000_0000, 0, 0, 0, 0, 0, 0, mk(8'h40, 0, 1, 2'b01, 0), 0, "R2 super-only user");
    send(32'h4000_0000, 1, 0, 0, 0, 0, 0, mk(8'h40, 0, 1, 2'b01, 0), 0, "R2 super-only super");
    send(32'h4000_0000, 1, 0, 0, 0, 0, 0, mk(8'h40, 0, 1, 2'b11, 0), 0, "R2 any super");
    send(32'h4000_0000, 0, 0, 0, 0, 0, 0, mk(8'h40, 0, 1, 2'b10, 0), 0, "R2 any user");
    // R3 mask
    send(32'h4AFF_FFFF, 0, 0, 0, 0, 0, 0, mk(8'h40, 8'h0F, 1, 2'b10, 0), 0, "R3 masked low nibble");
    send(32'h5000_0000, 0, 0, 0, 0, 0, 0, mk(8'h40, 8'h0F, 1, 2'b10, 0), 0, "R3 outside window");
    send(32'hFF00_0000, 0, 0, 0, 0, 0, 0, mk(8'h00, 8'hFF, 1, 2'b10, 0), 0, "R3 all don't-care");
    send(32'h41FF_FFFF, 0, 0, 0, 0, 0, 0, mk(8'h40, 8'h00, 1, 2'b10, 0), 0, "R3 exact miss");
    send(32'h0012_3456, 0, 0, 0, 0, 0, 0, mk(8'h80, 8'h80, 1, 2'b10, 0), 0, "R3 top bit ignored");
    // R4 bank select
    send(32'h4000_0000, 0, 0, 0, 0, mk(8'h40, 0, 1, 2'b10, 0), 0, 0, 0, "R4 data access code-only window");
    send(32'h4000_0000, 0, 1, 0, 0, 0, 0, mk(8'h40, 0, 1, 2'b10, 0), 0, "R4 code access data-only window");
    // R5 priority
    w0 = mk(8'h40, 0, 1, 2'b10, 1); w1 = mk(8'h40, 0, 1, 2'b10, 0);
    send(32'h4000_0000, 0, 1, 0, 0, w0, w1, 0, 0, "R5 reg0 protected wins");
    send(32'h4000_0000, 0, 1, 0, 0, w1, w0, 0, 0, "R5 reg0 writable wins");
    send(32'h4000_0000, 0, 0, 0, 0, 0, 0, mk(8'h20, 0, 1, 2'b10, 0), w0, "R5 fallthrough to reg1");
    // R6 / R7 protection
    send(32'h4000_0000, 0, 0, 1, 0, 0, 0, w0, 0, "R7 store protected");
    send(32'h4000_0000, 0, 0, 1, 0, 0, 0, w1, 0, "R7 store writable");
    send(32'h4000_0000, 0, 0, 0, 0, 0, 0, w0, 0, "R6 load protected");
    send(32'h5000_0000, 0, 0, 1, 0, 0, 0, w0, 0, "R7 store miss");
    // R8 probe
    send(32'h4000_0000, 1, 0, 0, 1, 0, 0, w0, 0, "R8 probe hit");
    send(32'h6000_0000, 1, 0, 0, 1, 0, 0, w0, 0, "R8 probe miss");
    send(32'h4000_0000, 1, 0, 0, 0, 0, 0, w1, 0, "R8 no probe");

    // mixed traffic under back-pressure
    stall_en = 1;
    for (int n = 0; n < 400; n++) begin
      ra = $urandom; rb = $urandom;
      w0 = $urandom; w1 = $urandom;
      if (n % 2 == 0) w0[31:24] = ra[31:24] ^ (8'h01 << (n % 8));
      if (n % 3 == 0) w1[31:24] = ra[31:24];
      send(ra, rb[0], rb[1], rb[2], rb[3], w0, w1, w1, w0, "R6 mixed traffic");
    end

    for (int k = 0; k < 200 && q.size() != 0; k++) @(negedge clk);
    chk(q.size() == 0, "R9 drain", q.size(), 64'd0);
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule